// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two reset causes into one active-low system reset. The first cause is a supply-good flag that is already synchronous to the block clock. The second is an asynchronous, active-low manual reset button input. A low supply flag pulls the reset output low on the next clock edge. A manual reset pulls it low once the pulse has lasted long enough to count as real.

When no cause is present, a release timer counts a fixed hold period and then lets the reset output go high. The count starts again from zero each time a cause comes back during the hold. The output is therefore released only after one full, uninterrupted period that is measured from the last time a cause was removed.

The clock frequency, the hold time and the minimum manual pulse width are all parameters. The two cycle counts are derived from them. A one-bit status output shows when the release timer is counting.

Top module: `supv_reset_gen`

## Requirements
- R1: While the asynchronous block reset `rst_n` is low, `sys_rst_n_o` and `hold_busy_o` are both 0. After `rst_n` is released, the first hold period has to complete before `sys_rst_n_o` goes high.
- R2: If `supply_ok_i` is sampled at 0 on a clock edge, `sys_rst_n_o` is 0 after that same edge. It stays 0 for as long as the flag is 0, no matter what state the timer is in.
- R3: Let E be the first edge at which no cause is present. `sys_rst_n_o` stays 0 through edge E+HOLD_CYC-1 and becomes 1 after edge E+HOLD_CYC.
- R4: If the supply flag drops during a hold period, the timer is cleared on the next edge (`hold_busy_o` becomes 0). When the flag returns, a new full period starts.
- R5: A low level on `man_rst_n_i` is counted as a manual reset once it has been sampled on at least QUAL_CYC consecutive edges. Take the edge c+1 that first samples the low level. The output is then still 1 after edge c+QUAL_CYC+2 and is 0 after edge c+QUAL_CYC+3.
- R6: A low pulse on `man_rst_n_i` that is sampled on fewer than QUAL_CYC edges has no effect. `sys_rst_n_o` stays 1 and `hold_busy_o` stays 0.
- R7: While a qualified manual reset is held, `sys_rst_n_o` and `hold_busy_o` are both 0. Let r+1 be the first edge that samples `man_rst_n_i` high again. The hold period then begins at edge r+4, which acts as E in R3.
- R8: `hold_busy_o` is 1 after edges E through E+HOLD_CYC-2 and 0 after edge E+HOLD_CYC-1. `sys_rst_n_o` is 0 whenever `hold_busy_o` is 1.
- R9: A manual reset that is qualified during a hold period clears the timer. Release then needs a new full period after the manual reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset. It is asserted asynchronously and released synchronously outside this block. |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, synchronous to `clk` |
| man_rst_n_i | input | 1 | Asynchronous active-low manual reset request |
| sys_rst_n_o | output | 1 | Registered active-low system reset |
| hold_busy_o | output | 1 | High while the release timer is counting |

## Verification
Each result has a fixed latency. A supply drop shows at the output one edge after it is sampled. A manual reset needs two synchroniser edges, then QUAL_CYC qualifying edges, then one edge in the output register. Release comes HOLD_CYC edges after the first clean edge, and the busy flag falls one edge before the output rises. The driver computes each expected value from these counts against a free-running edge counter and queues it with its due edge. The monitor compares only at the falling clock edge that follows that edge. The bench also checks the last cycle before each change as well as the cycle of the change, so an off-by-one shift in any stage is reported.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Number of clock cycles in a span of microseconds
  function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                               input int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction

  // Number of clock cycles in a span of nanoseconds, rounded up
  function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                               input int unsigned ns);
    int unsigned raw;
    raw = (clk_hz / 1_000_000) * ns;
    return (raw + 999) / 1000;
  endfunction

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic meta_q;
  logic stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= RST_VAL;
      stable_q <= RST_VAL;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
  parameter int unsigned QUAL_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_sync_i,
  output logic mr_act_o
);

  localparam int unsigned CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] run_q, run_d;
  logic          act_q, act_d;
  logic          run_en;

  // Count consecutive low samples; the count stops at the qualifying value
  always_comb begin
    run_d  = run_q;
    act_d  = act_q;
    run_en = 1'b0;
    if (mr_n_sync_i) begin
      run_d  = '0;
      act_d  = 1'b0;
      run_en = 1'b1;
    end else if (!act_q) begin
      if (run_q == LAST) begin
        act_d = 1'b1;
      end else begin
        run_d  = run_q + 1'b1;
        run_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      act_q <= act_d;
    end
  end

  assign mr_act_o = act_q;

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned HOLD_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic done_o,
  output logic busy_o
);

  localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
      cnt_en = 1'b1;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        done_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign busy_o = (cnt_q != '0) && !done_q;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned HOLD_US      = 200_000,
  parameter int unsigned MIN_PULSE_NS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  output logic sys_rst_n_o,
  output logic hold_busy_o
);

  localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);
  localparam int unsigned QUAL_CYC = ns_to_cycles(CLK_HZ, MIN_PULSE_NS);

  logic mr_n_sync;
  logic mr_act;
  logic cause;
  logic hold_done;
  logic out_q, out_d;

  supv_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (man_rst_n_i),
    .sync_o  (mr_n_sync)
  );

  supv_mr_qual #(.QUAL_CYC(QUAL_CYC)) u_mr_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .mr_n_sync_i (mr_n_sync),
    .mr_act_o    (mr_act)
  );

  assign cause = !supply_ok_i || mr_act;

  supv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cause),
    .done_o  (hold_done),
    .busy_o  (hold_busy_o)
  );

  always_comb begin
    out_d = !cause && hold_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign sys_rst_n_o = out_q;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_i,
  input logic mr_act,
  input logic sys_rst_n_o,
  input logic hold_busy_o
);

  p_supply_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !sys_rst_n_o);

  p_supply_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !hold_busy_o);

  p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mr_act |=> (!sys_rst_n_o && !hold_busy_o));

  p_busy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy_o |-> !sys_rst_n_o);

  p_rise_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> $past(hold_busy_o, 2));

endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok_i (supply_ok_i),
  .mr_act      (mr_act),
  .sys_rst_n_o (sys_rst_n_o),
  .hold_busy_o (hold_busy_o)
);

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;

  localparam int unsigned CLK_HZ   = 250_000_000;
  localparam int unsigned HOLD_US  = 1;
  localparam int unsigned PULSE_NS = 40;
  localparam int HOLD = 250;   // 1 us at 250 MHz
  localparam int QUAL = 10;    // 40 ns at 250 MHz

  typedef struct {
    int    due;
    logic  rst;
    logic  chk_busy;
    logic  busy;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic man_rst_n = 1'b1;
  logic sys_rst_n;
  logic busy;
  int   cyc;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  supv_reset_gen #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US), .MIN_PULSE_NS(PULSE_NS)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok),
    .man_rst_n_i (man_rst_n),
    .sys_rst_n_o (sys_rst_n),
    .hold_busy_o (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, expv);
    end
  endtask

  task automatic push(input int due, input logic r, input logic cb, input logic b, input string tag);
    exp_t e;
    e.due = due; e.rst = r; e.chk_busy = cb; e.busy = b; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_release(input int e);
    push(e, 1'b0, 1'b1, 1'b1, "R8");
    push(e + HOLD - 2, 1'b0, 1'b1, 1'b1, "R8");
    push(e + HOLD - 1, 1'b0, 1'b1, 1'b0, "R3");
    push(e + HOLD, 1'b1, 1'b1, 1'b0, "R3");
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations at the falling edge of their cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check(sb[i].tag, sys_rst_n, sb[i].rst, "sys_rst_n_o");
        if (sb[i].chk_busy) check(sb[i].tag, busy, sb[i].busy, "hold_busy_o");
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c;
    int e;
    int r;
    repeat (3) @(negedge clk);
    check("R1", sys_rst_n, 1'b0, "sys_rst_n_o in reset");
    check("R1", busy, 1'b0, "hold_busy_o in reset");
    rst_n = 1'b1;
    push_release(1);                       // R1: first full period after reset
    wait_until(HOLD + 6);

    // R2: supply drop forces reset on the next edge
    c = cyc; supply_ok = 1'b0;
    push(c + 1, 1'b0, 1'b1, 1'b0, "R2");
    push(c + 10, 1'b0, 1'b1, 1'b0, "R2");
    wait_until(c + 20);
    c = cyc; supply_ok = 1'b1;
    push_release(c + 1);
    wait_until(c + HOLD + 6);

    // R4: supply drop mid-count restarts the full period
    c = cyc; supply_ok = 1'b0;
    wait_until(c + 3); supply_ok = 1'b1;
    e = c + 4;
    push(e, 1'b0, 1'b1, 1'b1, "R4");
    wait_until(e + 100);
    c = cyc; supply_ok = 1'b0;
    push(c + 1, 1'b0, 1'b1, 1'b0, "R4");
    wait_until(c + 1); supply_ok = 1'b1;
    push_release(cyc + 1);
    wait_until(cyc + HOLD + 6);

    // R5 / R7: long manual reset, then release
    c = cyc; man_rst_n = 1'b0;
    push(c + QUAL + 2, 1'b1, 1'b1, 1'b0, "R5");
    push(c + QUAL + 3, 1'b0, 1'b1, 1'b0, "R5");
    push(c + 35, 1'b0, 1'b1, 1'b0, "R7");
    wait_until(c + 40);
    r = cyc; man_rst_n = 1'b1;
    push(r + 3, 1'b0, 1'b1, 1'b0, "R7");
    push_release(r + 4);
    wait_until(r + HOLD + 8);

    // R6: pulse one cycle short of qualification is ignored
    c = cyc; man_rst_n = 1'b0;
    wait_until(c + QUAL - 1); man_rst_n = 1'b1;
    push(c + QUAL + 2, 1'b1, 1'b1, 1'b0, "R6");
    push(c + QUAL + 3, 1'b1, 1'b1, 1'b0, "R6");
    push(c + QUAL + 10, 1'b1, 1'b1, 1'b0, "R6");
    wait_until(c + QUAL + 12);

    // R5 boundary: pulse of exactly the qualifying length
    c = cyc; man_rst_n = 1'b0;
    wait_until(c + QUAL); man_rst_n = 1'b1;
    push(c + QUAL + 2, 1'b1, 1'b1, 1'b0, "R5");
    push(c + QUAL + 3, 1'b0, 1'b1, 1'b0, "R5");
    push_release(c + QUAL + 4);
    wait_until(c + QUAL + HOLD + 8);

    // R9: manual reset during a hold period restarts it
    c = cyc; supply_ok = 1'b0;
    wait_until(c + 2); supply_ok = 1'b1;
    e = c + 3;
    push(e, 1'b0, 1'b1, 1'b1, "R9");
    wait_until(e + 50);
    c = cyc; man_rst_n = 1'b0;
    push(c + QUAL + 2, 1'b0, 1'b1, 1'b1, "R9");
    push(c + QUAL + 3, 1'b0, 1'b1, 1'b0, "R9");
    wait_until(c + 30);
    r = cyc; man_rst_n = 1'b1;
    push_release(r + 4);
    wait_until(r + HOLD + 10);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule